// File: doc/BRIEF.md
# Staggered Grayscale PWM Controller with LED Fault Sampling

This block drives sixteen LED channels with pulse-width modulation. It runs on a single grayscale clock, and a blanking input gates it. Each channel holds a 16-bit grayscale value. After blanking is released, a free-running 16-bit counter advances on every clock. Each channel is nominally lit while the counter is below that channel's value. To spread the supply surge, the channels are split into four groups by channel index modulo four. Group g reproduces its nominal waveform g clocks late, so both rising and falling edges arrive one group per clock.

Once per release of blanking, the block takes one fault sample: at the 33rd clock edge of the first counter period. At that edge it reads a per-channel digital input that stands in for an analog low-output-voltage comparator. A lit channel that reports low voltage and has a grayscale value of at least 0x1001 is flagged in a 16-bit status word. The same channel is then held dark until blanking is raised and released again. The open-drain fault pin is modelled as an active-low output enable, with the pin driven low whenever it is enabled. It is enabled while blanking is low and any visible status bit is set.

Top module: `gspwm_top`

## Requirements
- R1: While rst_n is low, chanOn reads 0, lodStatus reads 0 and errOeN reads 1.
- R2: Channel i's value is gsValue[16*i+15:16*i]. Counting k from 1 at each rising clock edge sampled with blank low since blank was last sampled high, a group-0 channel is on after edge k exactly when (k-1) mod 65536 is less than its value. A value of 0 never lights the channel.
- R3: Channel i belongs to group i mod 4. A group-g channel, after edge k, shows the group-0 rule evaluated at edge k-g, using the value applied at that edge. It is off while k is at most g. Both turn-on and turn-off are delayed this way.
- R4: Any edge that samples blank high restarts the count, and all chanOn bits read 0 after that edge.
- R5: At edge k=33 only, each bit of lodStatus is replaced by (chanOn before the edge) AND lowVolt AND (value >= 0x1001). Status bit i belongs to channel i.
- R6: A channel flagged at the sample edge is off from that edge onward. It lights again by the normal rule from the first edge after blank is released again.
- R7: lodStatus keeps its stored bits at every other edge, including edges with blank high, the second and later counter periods, and an edge where blank rises at what would have been edge 33.
- R8: Status bit i reads 0 while channel i's value is below 0x1001. The stored bit reappears once the value returns to 0x1001 or above.
- R9: errOeN is 0 exactly when blank is low and lodStatus is non-zero. It follows blank in the same cycle.
- R10: The count wraps after 65536 edges and PWM continues. No new sample is taken until blank is raised and released again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank | input | 1 | High: outputs dark, counter restarts |
| gsValue | input | 256 | Sixteen 16-bit grayscale values, channel 0 in the low bits |
| lowVolt | input | 16 | Per-channel low-output-voltage comparator result |
| chanOn | output | 16 | Per-channel current-sink enable |
| lodStatus | output | 16 | Per-channel fault status |
| errOeN | output | 1 | Active-low enable of the fault pin's low drive |

## Verification
The fault sample and the automatic turn-off land on the same edge. The bench raises lowVolt on lit channels and then confirms two things after edge 33: the status word changes, and those channels drop dark, both in that same cycle. The sample edge can also collide with the restart caused by blanking. The bench raises blank exactly at the 33rd edge and expects no status change. After the next release, the count starts again from one.

// File: rtl/gspwm_pkg.sv
package gspwm_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic run;     // blank low: counting and lighting allowed
    logic sample;  // this edge is the fault-sample edge
  } gsStrobe_t;

endpackage

// File: rtl/gspwm_ctrl.sv
module gspwm_ctrl
  import gspwm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SAMPLE_EDGE = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank,
  output gsStrobe_t        strobe,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] SAMPLE_CNT = CNT_W'(SAMPLE_EDGE - 1);
  localparam logic [CNT_W-1:0] CNT_LAST   = '1;

  logic firstPeriod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count       <= '0;
      firstPeriod <= 1'b1;
    end else if (blank) begin
      count       <= '0;
      firstPeriod <= 1'b1;
    end else begin
      count <= count + 1'b1;
      if (count == CNT_LAST) firstPeriod <= 1'b0;
    end
  end

  always_comb begin
    strobe.run    = !blank;
    strobe.sample = !blank && firstPeriod && (count == SAMPLE_CNT);
  end

endmodule

// File: rtl/gspwm_datapath.sv
module gspwm_datapath
  import gspwm_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int CNT_W   = 16,
  parameter int NUM_GRP = 4,
  parameter int LOD_MIN = 4097
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  gsStrobe_t               strobe,
  input  logic [CNT_W-1:0]        count,
  input  logic [NUM_CH*CNT_W-1:0] gsValue,
  input  logic [NUM_CH-1:0]       lowVolt,
  output logic [NUM_CH-1:0]       chanOn,
  output logic [NUM_CH-1:0]       lodStatus,
  output logic                    errOeN
);

  localparam logic [CNT_W-1:0] LOD_LIM = CNT_W'(LOD_MIN);

  logic [NUM_CH-1:0]               nomNext;
  logic [NUM_CH-1:0]               qualified;
  logic [NUM_CH-1:0]               delayedOn;
  logic [NUM_CH-1:0]               hit;
  logic [NUM_CH-1:0]               forceOff;
  logic [NUM_CH-1:0]               statusReg;
  logic [NUM_GRP-1:0][NUM_CH-1:0]  stage;

  // Per-channel compare against the counter and the fault threshold.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic [CNT_W-1:0] gsCh;
    assign gsCh         = gsValue[i*CNT_W +: CNT_W];
    assign nomNext[i]   = strobe.run && (count < gsCh);
    assign qualified[i] = (gsCh >= LOD_LIM);
    assign delayedOn[i] = stage[i % NUM_GRP][i];
  end

  // Stagger line: stage d is the nominal pattern delayed by d clocks.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
    end else begin
      stage[0] <= nomNext;
      for (int d = 1; d < NUM_GRP; d++) begin
        stage[d] <= strobe.run ? stage[d-1] : '0;
      end
    end
  end

  assign chanOn = delayedOn & ~forceOff;
  assign hit    = chanOn & lowVolt & qualified;

  // Fault latch and automatic turn-off.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      forceOff  <= '0;
      statusReg <= '0;
    end else begin
      if (!strobe.run)        forceOff <= '0;
      else if (strobe.sample) forceOff <= forceOff | hit;
      if (strobe.sample) statusReg <= hit;
    end
  end

  assign lodStatus = statusReg & qualified;
  assign errOeN    = !(strobe.run && (|lodStatus));

endmodule

// File: rtl/gspwm_top.sv
module gspwm_top
  import gspwm_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int CNT_W       = 16,
  parameter int NUM_GRP     = 4,
  parameter int SAMPLE_EDGE = 33,
  parameter int LOD_MIN     = 4097
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    blank,
  input  logic [NUM_CH*CNT_W-1:0] gsValue,
  input  logic [NUM_CH-1:0]       lowVolt,
  output logic [NUM_CH-1:0]       chanOn,
  output logic [NUM_CH-1:0]       lodStatus,
  output logic                    errOeN
);

  gsStrobe_t        strobe;
  logic [CNT_W-1:0] count;

  gspwm_ctrl #(
    .CNT_W      (CNT_W),
    .SAMPLE_EDGE(SAMPLE_EDGE)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .blank (blank),
    .strobe(strobe),
    .count (count)
  );

  gspwm_datapath #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .NUM_GRP(NUM_GRP),
    .LOD_MIN(LOD_MIN)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .count    (count),
    .gsValue  (gsValue),
    .lowVolt  (lowVolt),
    .chanOn   (chanOn),
    .lodStatus(lodStatus),
    .errOeN   (errOeN)
  );

endmodule

// File: rtl/gspwm_checker.sv
module gspwm_checker #(
  parameter int NUM_CH  = 16,
  parameter int CNT_W   = 16,
  parameter int LOD_MIN = 4097
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    blank,
  input logic                    sample,
  input logic [NUM_CH*CNT_W-1:0] gsValue,
  input logic [NUM_CH-1:0]       chanOn,
  input logic [NUM_CH-1:0]       lodStatus,
  input logic                    errOeN
);

  // R4: an edge that sees blank high leaves every channel dark
  a_r4_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (chanOn == '0));

  // R9: the fault pin is released while blank is high
  a_r9_err_released: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> errOeN);

  // R9: the fault pin is only driven with a visible fault
  a_r9_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !errOeN |-> (!blank && (lodStatus != '0)));

  // R7: no sample edge and unchanged values keep the status word
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> ($stable(lodStatus) || !$stable(gsValue)));

  // R8: low grayscale values hide their status bit
  for (genvar i = 0; i < NUM_CH; i++) begin : g_thr
    a_r8_below_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      (gsValue[i*CNT_W +: CNT_W] < CNT_W'(LOD_MIN)) |-> !lodStatus[i]);
  end

endmodule

bind gspwm_top gspwm_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .LOD_MIN(LOD_MIN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .blank    (blank),
  .sample   (strobe.sample),
  .gsValue  (gsValue),
  .chanOn   (chanOn),
  .lodStatus(lodStatus),
  .errOeN   (errOeN)
);

// File: tb/gspwm_top_tb.sv
module gspwm_top_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         blank = 1'b1;
  logic [255:0] gsValue = '0;
  logic [15:0]  lowVolt = '0;
  logic [15:0]  chanOn;
  logic [15:0]  lodStatus;
  logic         errOeN;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] on;
    logic [15:0] st;
    logic        err;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  // Model state built from the requirements
  int           kEdge = 0;
  logic [15:0]  mOn = '0, mStatus = '0, mForced = '0;
  logic [255:0] hist [4];

  always #2 clk = ~clk;  // 250 MHz

  gspwm_top u_dut (
    .clk(clk), .rst_n(rst_n), .blank(blank), .gsValue(gsValue),
    .lowVolt(lowVolt), .chanOn(chanOn), .lodStatus(lodStatus), .errOeN(errOeN)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] qualOf(input logic [255:0] g);
    logic [15:0] q;
    for (int c = 0; c < 16; c++) q[c] = (g[c*16 +: 16] >= 16'h1001);
    return q;
  endfunction

  // Driver: apply inputs, then push the expected post-edge state.
  task automatic step(input logic b, input logic [255:0] g, input logic [15:0] lv,
                      input string tag);
    exp_t e;
    logic [15:0] hit;
    logic [15:0] vis;
    @(negedge clk);
    blank = b; gsValue = g; lowVolt = lv;
    @(posedge clk);
    hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = g;
    if (b) begin
      kEdge = 0; mForced = '0;
    end else begin
      kEdge++;
      if (kEdge == 33) begin
        hit = mOn & lv & qualOf(g);
        mStatus = hit;
        mForced = mForced | hit;
      end
    end
    for (int c = 0; c < 16; c++) begin
      int grp;
      grp = c % 4;
      mOn[c] = !b && (kEdge > grp) &&
               (((kEdge - grp - 1) % 65536) < int'(hist[grp][c*16 +: 16])) &&
               !mForced[c];
    end
    vis = mStatus & qualOf(g);
    e.on = mOn; e.st = vis; e.err = !(!b && (vis != '0)); e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic run(input int n, input logic b, input logic [255:0] g,
                     input logic [15:0] lv, input string tag);
    for (int s = 0; s < n; s++) step(b, g, lv, tag);
  endtask

  // Monitor: compare each pushed item just after its edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(chanOn == e.on, e.tag, "chanOn", chanOn, e.on);
        check(lodStatus == e.st, e.tag, "lodStatus", lodStatus, e.st);
        check(errOeN == e.err, e.tag, "errOeN", {15'd0, errOeN}, {15'd0, e.err});
      end
    end
  end

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    logic [255:0] gA, gB, gC, gD, gE;
    logic [15:0]  lvB;
    for (int i = 0; i < 4; i++) hist[i] = '0;
    for (int c = 0; c < 16; c++) begin
      gA[c*16 +: 16] = 16'(c * 5 + 2);
      gB[c*16 +: 16] = 16'h2000;
      gD[c*16 +: 16] = 16'h0100;
      gE[c*16 +: 16] = 16'h1001;
    end
    gA[4*16 +: 16] = 16'h0000;
    gA[12*16 +: 16] = 16'h0001;
    gB[5*16 +: 16] = 16'h1000;
    gB[6*16 +: 16] = 16'h1001;
    gB[9*16 +: 16] = 16'h0010;
    gC = gB;
    gC[1*16 +: 16] = 16'h0800;
    gE[0*16 +: 16] = 16'hFFFF;
    gE[3*16 +: 16] = 16'h8000;
    lvB = 16'b0100_0010_0110_0010;  // ch1,5,6,9,14

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(chanOn == '0, "R1", "chanOn", chanOn, '0);
    check(lodStatus == '0, "R1", "lodStatus", lodStatus, '0);
    check(errOeN == 1'b1, "R1", "errOeN", {15'd0, errOeN}, 16'd1);
    rst_n = 1'b1;

    run(3, 1, gA, '0, "R4");
    run(40, 0, gA, '0, "R2");
    run(40, 0, gA, '0, "R3");
    run(3, 1, gA, '0, "R4");
    // fault sample and forced-off on the same edge
    run(32, 0, gB, lvB, "R5");
    run(1, 0, gB, lvB, "R5");
    run(30, 0, gB, lvB, "R6");
    run(5, 1, gB, lvB, "R9");
    run(3, 1, gB, '0, "R7");
    run(5, 0, gB, '0, "R6");
    run(27, 0, gB, '0, "R7");
    run(5, 0, gB, '0, "R5");
    // set flags again, then blank rises on the 33rd edge
    run(2, 1, gB, lvB, "R4");
    run(40, 0, gB, lvB, "R5");
    run(2, 1, gB, '0, "R7");
    run(32, 0, gB, '0, "R7");
    run(1, 1, gB, '0, "R7");
    run(20, 0, gB, '0, "R7");
    // threshold gating of visible status
    run(2, 1, gB, lvB, "R4");
    run(40, 0, gB, lvB, "R5");
    run(10, 0, gC, lvB, "R8");
    run(5, 0, gB, lvB, "R8");
    run(5, 0, gD, lvB, "R9");
    // full-period wrap without a second sample
    run(2, 1, gE, '0, "R4");
    run(65600, 0, gE, '0, "R10");
    run(100, 0, gE, 16'hFFFF, "R10");
    run(2, 1, gE, '0, "R9");

    repeat (3) @(posedge clk);
    finishRun();
  end

endmodule